// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is the bus-facing engine of a small serial EEPROM. SCL and SDA come in as plain inputs and are oversampled by the system clock. The engine recognises START and STOP conditions and shifts bytes in and out. It answers only to its own device address and pulls SDA low, through an active-low drive enable, to acknowledge or to send read data. It also keeps the byte pointer into the array.

It supports three kinds of transfer. A write delivers data bytes to a page-buffer port and asks for a commit after STOP. A read returns bytes fetched through a one-cycle synchronous memory port. A selective read is a write that carries only a byte address, followed by a repeated START with the read bit set. The array size is a parameter from 256 to 2048 bytes. Above 256 bytes, some bits of the device address byte act as memory address bits. While the array reports a write in progress, the engine does not acknowledge its address, so a master can poll for completion.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the engine is idle with SDA released, and no read, write or commit strobe is active.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP always returns the engine to idle with SDA released. From idle, nothing but a START is acted on.
- R3: An address byte is accepted only if bits 7..4 are 1010. The device-select field is bits 3..1, and `dev_pins_i[k]` is compared with byte bit k+1 for each k of at least log2(MEM_BYTES)-8. If the address does not match, no ACK is given and the bus is ignored until the next START.
- R4: When a byte address is received, the pointer is loaded with the uncompared low field bits as its high part (byte bit 1 becomes pointer bit 8, and so on) and the byte address as its low 8 bits.
- R5: The engine pulls SDA low during the ninth clock to acknowledge a matching address byte, and again for every byte written. SDA is only ever pulled low, and the pull changes only while SCL is low.
- R6: Each written data byte appears for one cycle on the write port with the current pointer. The pointer then steps only in its low 4 bits, wrapping within a 16-byte page, and its upper bits stay the same.
- R7: After a STOP, `wr_commit_o` pulses for one cycle if at least one data byte was written since the START. A transfer that carries only a byte address gives no commit.
- R8: While `busy_i` is high, the engine gives no ACK to its own device address.
- R9: A read that has no preceding byte address starts at the pointer, which is the last address accessed plus one.
- R10: During a read the pointer steps through the whole array and wraps from the top address to 0.
- R11: After a byte is sent, an ACK from the master (SDA low in the ninth clock) starts the next byte. A NACK ends sending: SDA stays released until a STOP.
- R12: A START in the middle of a transfer restarts address reception at bit 0.
- R13: After a byte address is acknowledged, a repeated START with the read bit set returns data starting at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| dev_pins_i | input | 3 | Strapped device-select bits (bit 2 down to bit 0) |
| busy_i | input | 1 | Array write cycle in progress |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe for a written data byte |
| wr_addr_o | output | log2(MEM_BYTES) | Array address of the written byte |
| wr_data_o | output | 8 | Written data byte |
| wr_commit_o | output | 1 | One-cycle request to program the page buffer |
| rd_en_o | output | 1 | Read request to the array |
| rd_addr_o | output | log2(MEM_BYTES) | Array address to read |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |

## Verification
The assertions check the rules that hold on every cycle. The SDA pull never changes while SCL is high. A STOP puts the engine back in idle with the line released, and a START sends it back to address reception. The engine never acknowledges while the array is busy. A commit only follows a STOP, and write strobes occur only in the write-acknowledge phase. Other behaviours need whole transactions to show and are left to the bench scenarios: the address match under the size-dependent field split, the page wrap on writes, the full-array wrap on reads, the selective read, the quiet line after a master NACK, and a START that breaks into a byte.

// File: rtl/eei_pkg.sv
package eei_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADR, S_WADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK, S_HOLD
  } st_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  // prefix must match; field bit k+1 is compared with pin k where k >= aw-8
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] pins,
                                   input int aw);
    logic hit;
    hit = (b[7:4] == DEV_PREFIX);
    for (int i = 0; i < 3; i++) begin
      if (i >= aw - 8 && b[i+1] != pins[i]) hit = 1'b0;
    end
    return hit;
  endfunction

  // field bits become high pointer bits above the byte address
  function automatic logic [10:0] join_addr(input logic [3:0] dev_lo,
                                            input logic [7:0] word);
    return {dev_lo[3:1], word};
  endfunction

  // increment over the whole array
  function automatic logic [10:0] wrap_inc(input logic [10:0] a, input int aw);
    logic [10:0] m;
    m = 11'((1 << aw) - 1);
    return (a + 11'd1) & m;
  endfunction

  // increment of the low page bits only
  function automatic logic [10:0] page_inc(input logic [10:0] a, input int pb);
    logic [10:0] m;
    m = 11'((1 << pb) - 1);
    return (a & ~m) | ((a + 11'd1) & m);
  endfunction

endpackage

// File: rtl/eei_bus_sampler.sv
module eei_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
          sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eei_addr_ctr.sv
module eei_addr_ctr #(
  parameter int AW        = 9,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_full,
  input  logic          step_page,
  output logic [AW-1:0] ptr
);
  logic [10:0] ptr_x;
  assign ptr_x = 11'(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (load)      ptr <= load_val;
    else if (step_full) ptr <= AW'(eei_pkg::wrap_inc(ptr_x, AW));
    else if (step_page) ptr <= AW'(eei_pkg::page_inc(ptr_x, PAGE_BITS));
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int MEM_BYTES = 512,
  parameter int PAGE_BITS = 4,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    dev_pins_i,
  input  logic          busy_i,
  output logic          sda_pull_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  import eei_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;

  eei_bus_sampler #(.STAGES(2)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  st_t         st;
  logic [3:0]  bitcnt;
  logic [7:0]  rx_sh, tx_sh, tx_buf;
  logic [3:0]  dev_lo;
  logic        wrote, mack, rd_pend;
  logic [AW-1:0] ptr;

  // named internal events
  logic quiet, rx_state, shift_en, byte_in, dev_done, addr_hit, dev_ack;
  logic rd_first, wadr_done, wdat_done, mack_rise, rd_issue;
  logic [7:0] rx_next;

  always_comb begin
    quiet     = !ev_start && !ev_stop;
    rx_state  = (st == S_DEV) || (st == S_WADR) || (st == S_WDAT);
    shift_en  = quiet && scl_rise && rx_state && (bitcnt < 4'd8);
    rx_next   = {rx_sh[6:0], sda_s};
    byte_in   = quiet && scl_fall && (bitcnt == 4'd8);
    dev_done  = byte_in && (st == S_DEV);
    addr_hit  = dev_hit(rx_sh, dev_pins_i, AW) && !busy_i;
    dev_ack   = dev_done && addr_hit;
    rd_first  = dev_ack && rx_sh[0];
    wadr_done = byte_in && (st == S_WADR);
    wdat_done = byte_in && (st == S_WDAT);
    mack_rise = quiet && (st == S_RACK) && scl_rise && !sda_s;
    rd_issue  = rd_first || mack_rise;
  end

  eei_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(wadr_done), .load_val(AW'(join_addr(dev_lo, rx_sh))),
    .step_full(rd_issue), .step_page(wdat_done), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bitcnt      <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      tx_buf      <= '0;
      dev_lo      <= '0;
      wrote       <= 1'b0;
      mack        <= 1'b0;
      rd_pend     <= 1'b0;
      sda_pull_o  <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
      rd_en_o     <= 1'b0;
      rd_addr_o   <= '0;
    end else begin
      rd_en_o     <= 1'b0;
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      rd_pend     <= rd_en_o;
      if (rd_pend) tx_buf <= rd_data_i;
      if (shift_en) begin
        rx_sh  <= rx_next;
        bitcnt <= bitcnt + 4'd1;
      end
      if (rd_issue) begin
        rd_en_o   <= 1'b1;
        rd_addr_o <= ptr;
      end
      if (ev_stop) begin
        st          <= S_IDLE;
        sda_pull_o  <= 1'b0;
        wr_commit_o <= wrote;
        wrote       <= 1'b0;
        mack        <= 1'b0;
      end else if (ev_start) begin
        st         <= S_DEV;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
        wrote      <= 1'b0;
        mack       <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_DEV: if (dev_done) begin
            if (addr_hit) begin
              st         <= S_DEV_ACK;
              sda_pull_o <= 1'b1;
              dev_lo     <= rx_sh[3:0];
            end else begin
              st <= S_IDLE;
            end
          end
          S_DEV_ACK: if (scl_fall) begin
            if (dev_lo[0]) begin
              st         <= S_RDAT;
              tx_sh      <= tx_buf;
              sda_pull_o <= ~tx_buf[7];
              bitcnt     <= 4'd1;
            end else begin
              st         <= S_WADR;
              sda_pull_o <= 1'b0;
              bitcnt     <= '0;
            end
          end
          S_WADR: if (wadr_done) begin
            st         <= S_WADR_ACK;
            sda_pull_o <= 1'b1;
          end
          S_WADR_ACK, S_WDAT_ACK: if (scl_fall) begin
            st         <= S_WDAT;
            sda_pull_o <= 1'b0;
            bitcnt     <= '0;
          end
          S_WDAT: if (wdat_done) begin
            st         <= S_WDAT_ACK;
            sda_pull_o <= 1'b1;
            wr_valid_o <= 1'b1;
            wr_addr_o  <= ptr;
            wr_data_o  <= rx_sh;
            wrote      <= 1'b1;
          end
          S_RDAT: if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              st         <= S_RACK;
              sda_pull_o <= 1'b0;
            end else begin
              tx_sh      <= {tx_sh[6:0], 1'b0};
              sda_pull_o <= ~tx_sh[6];
              bitcnt     <= bitcnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              if (sda_s) st <= S_HOLD;
              else       mack <= 1'b1;
            end else if (scl_fall && mack) begin
              mack       <= 1'b0;
              st         <= S_RDAT;
              tx_sh      <= tx_buf;
              sda_pull_o <= ~tx_buf[7];
              bitcnt     <= 4'd1;
            end
          end
          S_HOLD: sda_pull_o <= 1'b0;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/eei_checker.sv
module eei_checker (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          scl_fall,
  input logic          busy_i,
  input logic [3:0]    bitcnt,
  input eei_pkg::st_t  st,
  input logic          sda_pull_o,
  input logic          wr_valid_o,
  input logic          rd_en_o,
  input logic          wr_commit_o
);
  import eei_pkg::*;

  logic armed, pull_q, stop_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      pull_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      armed  <= 1'b1;
      pull_q <= sda_pull_o;
      stop_q <= ev_stop;
    end
  end

  // R5
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sda_pull_o != pull_q) |-> !scl_lvl);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_pull_o && st == S_IDLE));

  // R12
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (st == S_DEV));

  // R8
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEV && scl_fall && bitcnt == 4'd8 && busy_i && !ev_start && !ev_stop)
      |=> !sda_pull_o);

  // R7
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> (armed && stop_q));

  // R6
  write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (st == S_WDAT_ACK && !rd_en_o));
endmodule

bind eeprom_i2c_slave eei_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .ev_start(ev_start),
  .ev_stop(ev_stop), .scl_fall(scl_fall), .busy_i(busy_i), .bitcnt(bitcnt),
  .st(st), .sda_pull_o(sda_pull_o), .wr_valid_o(wr_valid_o),
  .rd_en_o(rd_en_o), .wr_commit_o(wr_commit_o)
);

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM       = 512;
  localparam int AW        = 9;
  localparam int HP        = 8;
  localparam int BUSY_CYC  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic busy_i = 1'b0;
  logic [2:0] pins = 3'b101;
  logic sda_pull_o, wr_valid_o, wr_commit_o, rd_en_o;
  logic [AW-1:0] wr_addr_o, rd_addr_o;
  logic [7:0] wr_data_o;
  logic [7:0] rd_data = 8'h00;
  wire sda_line = sda_m & ~sda_pull_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_i2c_slave #(.MEM_BYTES(MEM)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_pins_i(pins), .busy_i(busy_i), .sda_pull_o(sda_pull_o),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_commit_o(wr_commit_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data)
  );

  int checks = 0;
  int errors = 0;
  int commits = 0;
  int busy_left = 0;
  logic [7:0] arr [0:MEM-1];
  logic [7:0] ref_mem [0:MEM-1];
  logic [16:0] wr_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // array model: one-cycle read, writes land from the write port
  always @(posedge clk) begin
    if (rd_en_o) rd_data <= arr[rd_addr_o];
    if (wr_valid_o) arr[wr_addr_o] <= wr_data_o;
  end

  // busy window after each commit
  always @(negedge clk) begin
    if (wr_commit_o) begin
      commits++;
      busy_left = BUSY_CYC;
      busy_i = 1'b1;
    end else if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0) busy_i = 1'b0;
    end
  end

  // scoreboard monitor for the write port (R4, R6)
  always @(negedge clk) begin
    if (wr_valid_o) begin
      if (wr_q.size() == 0) begin
        chk(1'b0, "R6 unexpected write", int'({wr_addr_o, wr_data_o}), 0);
      end else begin
        logic [16:0] e;
        e = wr_q.pop_front();
        chk({8'(0), wr_addr_o, wr_data_o} == {8'(0), e}, "R6/R4 write item",
            int'({wr_addr_o, wr_data_o}), int'(e));
      end
    end
  end

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    sda_m = 1'b1; hp(); scl = 1'b1;
    repeat (HP/2) @(negedge clk);
    ack = (sda_line == 1'b0);
    repeat (HP/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1'b1;
      repeat (HP/2) @(negedge clk);
      b[i] = sda_line;
      repeat (HP/2) @(negedge clk);
      scl = 1'b0;
    end
    sda_m = ~give_ack; hp(); scl = 1'b1; hp(); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_q.push_back({a, d});
    ref_mem[a] = d;
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic give_ack, input string tag);
    logic [7:0] got;
    read_byte(give_ack, got);
    chk(got == ref_mem[a], tag, int'(got), int'(ref_mem[a]));
  endtask

  task automatic wait_idle_array();
    while (busy_i) @(negedge clk);
    hp();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    int c0;
    for (int i = 0; i < MEM; i++) begin
      arr[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(sda_pull_o == 1'b0, "R1 sda released", int'(sda_pull_o), 0);
    chk({wr_valid_o, rd_en_o, wr_commit_o} == 3'b000, "R1 strobes idle",
        int'({wr_valid_o, rd_en_o, wr_commit_o}), 0);

    // R3 wrong strap bit A1 (0xAE), then a further byte is ignored
    bus_start();
    send_byte(8'hAE, ack); chk(!ack, "R3 pin mismatch nack", int'(ack), 0);
    send_byte(8'h34, ack); chk(!ack, "R3 ignored until START", int'(ack), 0);
    bus_stop();
    // R3 wrong prefix
    bus_start();
    send_byte(8'h2A, ack); chk(!ack, "R3 prefix mismatch nack", int'(ack), 0);
    bus_stop();

    // R4/R5/R7 byte write: field bit1 = addr bit 8, address 0x134
    c0 = commits;
    bus_start();
    send_byte(8'hAA, ack); chk(ack, "R5 address ack", int'(ack), 1);
    send_byte(8'h34, ack); chk(ack, "R5 byte address ack", int'(ack), 1);
    push_wr(9'h134, 8'hA5);
    send_byte(8'hA5, ack); chk(ack, "R5 data ack", int'(ack), 1);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(commits == c0 + 1, "R7 commit after write", commits - c0, 1);

    // R8 polling while busy
    chk(busy_i == 1'b1, "R8 array busy", int'(busy_i), 1);
    bus_start();
    send_byte(8'hAA, ack); chk(!ack, "R8 nack while busy", int'(ack), 0);
    bus_stop();
    wait_idle_array();
    bus_start();
    send_byte(8'hAA, ack); chk(ack, "R8 ack after busy", int'(ack), 1);
    bus_stop();

    // R9 immediate read from last+1 = 0x135
    bus_start();
    send_byte(8'hA9, ack); chk(ack, "R9 read address ack", int'(ack), 1);
    expect_read(9'h135, 1'b0, "R9 immediate read data");
    bus_stop();

    // R13/R10/R11 selective read at 0x1FE with wrap, dummy write no commit
    c0 = commits;
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'hFE, ack); chk(ack, "R13 byte address ack", int'(ack), 1);
    bus_start();
    send_byte(8'hAB, ack); chk(ack, "R13 read after repeated START", int'(ack), 1);
    expect_read(9'h1FE, 1'b1, "R13 selective data");
    expect_read(9'h1FF, 1'b1, "R10 sequential top");
    expect_read(9'h000, 1'b0, "R10 wrap to zero");
    // R11 after NACK the line stays released for a whole byte
    begin
      logic [7:0] idle_b;
      read_byte(1'b0, idle_b);
      chk(idle_b == 8'hFF, "R11 quiet after nack", int'(idle_b), 8'hFF);
    end
    bus_stop();
    repeat (4) @(negedge clk);
    chk(commits == c0, "R7 no commit for dummy write", commits - c0, 0);

    // R6 page write wrap: 0x00E, 0x00F, 0x000
    bus_start();
    send_byte(8'hA8, ack);
    send_byte(8'h0E, ack);
    push_wr(9'h00E, 8'hD0); send_byte(8'hD0, ack);
    push_wr(9'h00F, 8'hD1); send_byte(8'hD1, ack);
    push_wr(9'h000, 8'hD2); send_byte(8'hD2, ack);
    chk(ack, "R5 last page byte ack", int'(ack), 1);
    bus_stop();
    wait_idle_array();
    chk(wr_q.size() == 0, "R6 all writes seen", wr_q.size(), 0);

    // R10 read crosses page boundary (0x00F -> 0x010)
    bus_start();
    send_byte(8'hA8, ack); send_byte(8'h0E, ack);
    bus_start(); send_byte(8'hA9, ack);
    expect_read(9'h00E, 1'b1, "R6 readback first");
    expect_read(9'h00F, 1'b1, "R6 readback second");
    expect_read(9'h010, 1'b0, "R10 read crosses page");
    bus_stop();
    bus_start();
    send_byte(8'hA8, ack); send_byte(8'h00, ack);
    bus_start(); send_byte(8'hA9, ack);
    expect_read(9'h000, 1'b0, "R6 page wrapped byte");
    bus_stop();

    // R12 START in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    bus_start();
    send_byte(8'hA9, ack); chk(ack, "R12 restart address ack", int'(ack), 1);
    expect_read(9'h001, 1'b0, "R12 read after restart");
    bus_stop();
    repeat (4) @(negedge clk);
    chk(sda_pull_o == 1'b0, "R2 released after STOP", int'(sda_pull_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule